// File: doc/BRIEF.md
# Token-Strobed Dual-Edge Column Loader

This block fills a row of 32 channel latches, each seven bits wide, from a parallel bus that many devices share. A chip-select token decides which device on the bus is currently taking words. Once a device holds the token, every transition of the shift clock, rising or falling, strobes one bus word into the next channel slot. Words therefore arrive at twice the shift-clock frequency. After the final slot is written, the device hands the token to the next device in the cascade.

A direction input sets the slot order. It also decides which of the two token pins receives the token and which one passes it on, so the same part can be mounted on either edge of a panel. The block runs on a fast system clock. It samples the shift clock and the token pins through two-flop synchronizers and recognizes shift-clock transitions by comparing successive samples. The latched values stay on the outputs, so a downstream converter can use one frame while the next frame is being loaded.

Top module: `token_column_loader`

## Requirements
- R1: After reset every channel latch reads zero, both token outputs are low and no frame is in progress.
- R2: A rising shift-clock transition that sees the selected token input high starts a frame and writes the bus word into slot 0. Each later transition, falling then rising in turn, writes the next slot, so 32 words take 16 shift-clock periods.
- R3: With `dir_up` high, slot k lands in channel k, where channel k occupies bits [7k+6:7k] of `chan_q`. `tok_a_i` is the token input, `tok_b_o` is the token output and `tok_a_o` stays low.
- R4: With `dir_up` low, slot k lands in channel 31-k. `tok_b_i` is the token input, `tok_a_o` is the token output and `tok_b_o` stays low.
- R5: The selected token output goes high together with the capture of the final slot and falls on the next shift-clock transition. It is low during the rest of the frame.
- R6: Shift-clock transitions while no frame is in progress leave every latch unchanged. This covers transitions without a token, a token on the non-selected pin, and a falling transition while the token is high.
- R7: Latches hold their values between frames, and a new frame overwrites every channel with its own words.
- R8: The bus word is taken within three system cycles of a shift-clock transition. A bus change four or more cycles after the transition does not alter the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shclk | input | 1 | Shift clock; each transition strobes one word |
| dir_up | input | 1 | Slot order and token pin roles (1 = ascending) |
| tok_a_i | input | 1 | Token input used when `dir_up` is high |
| tok_b_i | input | 1 | Token input used when `dir_up` is low |
| bus_in | input | 7 | Shared pixel data bus |
| tok_a_o | output | 1 | Token output used when `dir_up` is low |
| tok_b_o | output | 1 | Token output used when `dir_up` is high |
| chan_q | output | 224 | 32 channel latches, channel k at bits [7k+6:7k] |

## Verification
Full 32-word frames are run in both directions, with word values computed from a seed and the slot number. Each slot is checked right after its own transition, which separates an ascending from a descending mapping and catches a counter that skips or repeats a slot. The token pulse is checked on the last two transitions of every frame and on the pin that is not selected, which tells apart an early, late or misrouted hand-off. Frames without a token, with the token on the wrong pin and with a falling-edge start are mixed in, along with a bus that changes late in every half period, to show that only real frames write and that each word is taken at its own transition.

// File: rtl/tcl_pkg.sv
package tcl_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } sc_evt_t;

  // Map a fill-order slot to a physical channel number.
  function automatic int unsigned chan_of_slot(int unsigned slot, logic up,
                                               int unsigned slots);
    return up ? slot : (slots - 1 - slot);
  endfunction

  function automatic logic is_last_slot(int unsigned slot, int unsigned slots);
    return slot == (slots - 1);
  endfunction

endpackage

// File: rtl/tcl_sync2.sv
module tcl_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/tcl_edge_det.sv
module tcl_edge_det
  import tcl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lvl,
  output sc_evt_t evt
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  always_comb begin
    evt.rise = lvl & ~prev;
    evt.fall = ~lvl & prev;
  end
endmodule

// File: rtl/tcl_sequencer.sv
module tcl_sequencer
  import tcl_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sc_evt_t           evt,
  input  logic              tok,
  output logic              cap_en,
  output logic [SLOT_W-1:0] cap_slot,
  output logic              active,
  output logic              tok_pulse
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic              any_edge;
  logic              start;
  logic              last_cap;
  logic [SLOT_W-1:0] cnt;

  assign any_edge = evt.rise | evt.fall;
  assign start    = ~active & evt.rise & tok;
  assign cap_en   = start | (active & any_edge);
  assign cap_slot = start ? '0 : cnt;
  assign last_cap = cap_en & is_last_slot(32'(cap_slot), SLOTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= SLOT_W'(1);
    end else if (active && any_edge) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        tok_pulse <= 1'b0;
    else if (last_cap) tok_pulse <= 1'b1;
    else if (any_edge) tok_pulse <= 1'b0;
  end
endmodule

// File: rtl/tcl_latch_bank.sv
module tcl_latch_bank #(
  parameter int SLOTS  = 32,
  parameter int WORD_W = 7,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SLOT_W-1:0]         wr_idx,
  input  logic [WORD_W-1:0]         wr_data,
  output logic [SLOTS*WORD_W-1:0]   q_flat
);
  for (genvar ch = 0; ch < SLOTS; ch++) begin : g_ch
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  q <= '0;
      else if (wr_en && (wr_idx == SLOT_W'(ch)))   q <= wr_data;
    end
    assign q_flat[ch*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/token_column_loader.sv
module token_column_loader
  import tcl_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int WORD_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shclk,
  input  logic                    dir_up,
  input  logic                    tok_a_i,
  input  logic                    tok_b_i,
  input  logic [WORD_W-1:0]       bus_in,
  output logic                    tok_a_o,
  output logic                    tok_b_o,
  output logic [SLOTS*WORD_W-1:0] chan_q
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [2:0]        raw_in, syn_in;
  logic              sc_s, tok_a_s, tok_b_s, tok_sync;
  sc_evt_t           evt;
  logic              rise_evt, edge_evt;
  logic              cap_en, active, tok_pulse;
  logic [SLOT_W-1:0] cap_slot, cap_chan;

  assign raw_in = {shclk, tok_a_i, tok_b_i};

  tcl_sync2 #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {sc_s, tok_a_s, tok_b_s} = syn_in;
  assign tok_sync = dir_up ? tok_a_s : tok_b_s;

  tcl_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sc_s), .evt(evt)
  );

  assign rise_evt = evt.rise;
  assign edge_evt = evt.rise | evt.fall;

  tcl_sequencer #(.SLOTS(SLOTS)) u_seq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .tok(tok_sync),
    .cap_en(cap_en), .cap_slot(cap_slot), .active(active),
    .tok_pulse(tok_pulse)
  );

  assign cap_chan = SLOT_W'(chan_of_slot(32'(cap_slot), dir_up, SLOTS));

  tcl_latch_bank #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_en), .wr_idx(cap_chan),
    .wr_data(bus_in), .q_flat(chan_q)
  );

  assign tok_a_o = ~dir_up & tok_pulse;
  assign tok_b_o =  dir_up & tok_pulse;
endmodule

// File: rtl/tcl_checker.sv
module tcl_checker #(
  parameter int SLOTS  = 32,
  parameter int WORD_W = 7,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dir_up,
  input logic                    rise_evt,
  input logic                    edge_evt,
  input logic                    tok_sync,
  input logic                    cap_en,
  input logic [SLOT_W-1:0]       cap_slot,
  input logic                    active,
  input logic                    tok_pulse,
  input logic                    tok_a_o,
  input logic                    tok_b_o,
  input logic [SLOTS*WORD_W-1:0] chan_q
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  AST_CAP_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> edge_evt); // R2

  AST_START_RISE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !active) |-> (rise_evt && tok_sync && cap_slot == '0)); // R6

  AST_LAST_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cap_slot == LAST) |=> !active); // R2

  AST_SLOT_HOLDS_IDLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !edge_evt) |=> (active && $stable(cap_slot))); // R2

  AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tok_pulse) |-> $past(cap_en && cap_slot == LAST)); // R5

  AST_PULSE_ENDS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tok_pulse) |-> $past(edge_evt)); // R5

  AST_OUT_PIN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    dir_up |-> !tok_a_o); // R3

  AST_OUT_PIN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_up |-> !tok_b_o); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(chan_q)); // R6
endmodule

bind token_column_loader tcl_checker #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .rise_evt(rise_evt),
  .edge_evt(edge_evt), .tok_sync(tok_sync), .cap_en(cap_en),
  .cap_slot(cap_slot), .active(active), .tok_pulse(tok_pulse),
  .tok_a_o(tok_a_o), .tok_b_o(tok_b_o), .chan_q(chan_q)
);

// File: tb/token_column_loader_tb.sv
`timescale 1ns/1ps
module token_column_loader_tb;
  localparam int SLOTS  = 32;
  localparam int WORD_W = 7;

  logic clk = 1'b0, rst_n = 1'b0, sc = 1'b0, dir_up = 1'b1;
  logic tka = 1'b0, tkb = 1'b0;
  logic [WORD_W-1:0] bus = '0;
  logic tka_o, tkb_o;
  logic [SLOTS*WORD_W-1:0] chan_q;

  int checks = 0, errors = 0;
  logic [WORD_W-1:0] model [SLOTS];

  always #2 clk = ~clk;

  token_column_loader #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .shclk(sc), .dir_up(dir_up),
    .tok_a_i(tka), .tok_b_i(tkb), .bus_in(bus),
    .tok_a_o(tka_o), .tok_b_o(tkb_o), .chan_q(chan_q)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int chan_val(int i);
    return int'(chan_q[i*WORD_W +: WORD_W]);
  endfunction

  function automatic logic [WORD_W-1:0] word_of(int seed, int k);
    return WORD_W'((seed * 29 + k * 37 + k * k * 3 + 5) % 128);
  endfunction

  // One half period: word valid before the transition, changed late (R8).
  task automatic half(logic lvl, logic [WORD_W-1:0] w);
    bus = w;
    wait_clk(2);
    sc = lvl;
    wait_clk(5);
    bus = ~w;
    wait_clk(3);
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < SLOTS; i++)
      chk(req, $sformatf("channel %0d", i), chan_val(i), int'(model[i]));
  endtask

  task automatic frame(logic up, int seed, logic wrong_pin);
    logic in_a;
    dir_up = up;
    in_a = up ^ wrong_pin;
    if (in_a) tka = 1'b1; else tkb = 1'b1;
    wait_clk(4);
    for (int k = 0; k < SLOTS; k++) begin
      half((k % 2 == 0) ? 1'b1 : 1'b0, word_of(seed, k));
      if (k == 0) begin tka = 1'b0; tkb = 1'b0; end
      if (!wrong_pin) begin
        int ch;
        ch = up ? k : SLOTS - 1 - k;
        model[ch] = word_of(seed, k);
        chk(up ? "R3 R8" : "R4 R8", $sformatf("slot %0d", k), chan_val(ch),
            int'(model[ch]));
      end
      if (k == SLOTS - 2)
        chk("R5", "token out before last slot", int'({tka_o, tkb_o}), 0);
      if (k == SLOTS - 1) begin
        if (wrong_pin)
          chk("R6", "token out on ignored frame", int'({tka_o, tkb_o}), 0);
        else
          chk("R5", "token out at last slot", int'({tka_o, tkb_o}),
              up ? 1 : 2);
      end
    end
    half(1'b1, 7'h55);
    chk("R5", "token out after next edge", int'({tka_o, tkb_o}), 0);
    half(1'b0, 7'h2a);
    check_all(wrong_pin ? "R6" : "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) model[i] = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R1: reset state
    check_all("R1");
    chk("R1", "token outputs after reset", int'({tka_o, tkb_o}), 0);

    // R2 R3: ascending frame
    frame(1'b1, 1, 1'b0);
    // R2 R4: descending frame
    frame(1'b0, 2, 1'b0);
    // R7: full overwrite by a new ascending frame
    frame(1'b1, 3, 1'b0);

    // R6: transitions with no token at all
    for (int k = 0; k < 8; k++) half((k % 2 == 0) ? 1'b1 : 1'b0, 7'h11);
    check_all("R6");
    chk("R6", "token out without token", int'({tka_o, tkb_o}), 0);

    // R6: token on the non-selected pin, both directions
    frame(1'b1, 4, 1'b1);
    frame(1'b0, 5, 1'b1);

    // R6: token high across a falling transition only
    dir_up = 1'b1;
    half(1'b1, 7'h33);
    tka = 1'b1;
    half(1'b0, 7'h44);
    tka = 1'b0;
    half(1'b1, 7'h66);
    half(1'b0, 7'h77);
    check_all("R6");

    // R4 R7: final descending frame over existing data
    frame(1'b0, 6, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule